// File: doc/BRIEF.md
# SPI Slave with Descriptor-Controlled Buffers

This block is an SPI slave in clock mode 0 that exchanges 8-bit characters with an external master. It has one receive buffer and one transmit buffer, each with a small descriptor. The receive descriptor holds an empty flag and a byte count. The transmit descriptor holds a ready flag and a length. Software fills the transmit buffer, marks the descriptors, and issues a start command. The slave then takes part in the next select period the master opens.

Each direction closes on its own terms. The receive side closes when it is full or when the master releases select. The transmit side closes once its programmed number of bytes has gone out. If select is released early, the transmit side stays ready and resumes from its next byte in a later armed session. Closing events, plus a busy error for bytes that arrive after the receive side has closed, collect in an event register. That register is cleared by writing ones, and a mask selects which events drive the interrupt line.

Top module: `spi_sd_slave`

## Requirements
- R1: After reset the event, mask and command registers read 0, both descriptors read 0 (receive not empty, transmit not ready), `irq` is low, and `spi_miso` is high whenever select is released.
- R2: In a select period that began while the slave was not armed, every byte returns 0xFF on MISO. Such bytes change no descriptor, buffer or event.
- R3: Received bits are sampled on rising SCLK, MSB first. Each byte is stored at the current count, and the count is incremented. Buffer slot i is read by writing i to the index register and then reading the receive-buffer address.
- R4: Transmit bits are driven MSB first. The first bit is valid on MISO before the first rising SCLK after select falls, and each later bit changes after a falling SCLK. Bytes come from transmit slots 0, 1, 2, … counted from the last write of the transmit descriptor.
- R5: When the byte at position length−1 has been sent, the transmit ready flag clears and event bit 1 (transmit closed) is set. Every later byte is 0xFF. A written length above 16 is stored as 16.
- R6: When select is released in an armed session with the receive side still empty, the receive empty flag clears, the count keeps the number of bytes received, and event bit 0 (receive closed) is set. The transmit ready flag and its send position are unchanged.
- R7: The receive buffer holds 16 bytes. The 16th byte clears the empty flag and sets event bit 0 at once. When exactly 16 bytes arrive and select is then released, no busy event is raised.
- R8: A byte that completes in an armed session while the receive empty flag is clear sets event bit 2 (busy) and is dropped. The count and buffer contents stay as they were.
- R9: Writing the event register clears every bit written as 1 and leaves bits written as 0. Writing 0xFF clears all events. A hardware set in the same cycle wins.
- R10: `irq` is high exactly when some event bit and its mask bit are both 1.
- R11: Writing 1 to command bit 0 arms the slave. The slave takes part in the next select period and disarms when that period ends. A new transfer needs the start command, the receive empty flag (a write with bit 7 set, which also zeroes the count) and the transmit ready flag set again.
- R12: Register map. The register address selects one register. Address 0 is the command, with bit 0 = start on write and armed on read. Address 1 holds the events and address 2 the mask, both in bits 2:0. Address 3 is the receive descriptor: bit 7 is empty and bits 4:0 are the count. Address 4 is the transmit descriptor: bit 7 is ready and bits 4:0 are the length. Address 5 is the buffer index. Address 6 reads the receive buffer and address 7 writes the transmit buffer, both at that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| irq | output | 1 | Masked OR of pending events |

## Verification
Three receive patterns are used. A session shorter than both limits separates closing on deselect from closing on length. A session of exactly 16 bytes shows that filling the buffer alone raises no busy error. A session of 18 bytes shows that busy is raised and that later bytes are dropped. On the transmit side, a five-byte buffer is sent across two sessions, which checks that the send position survives a deselect and that 0xFF follows the close. A session that is not armed, partial event clears and masked interrupts separate the command, the event and the mask paths.

// File: rtl/spi_sd_pkg.sv
package spi_sd_pkg;

  localparam int CHAR_W   = 8;
  localparam int REG_W    = 8;
  localparam int EVT_N    = 3;
  localparam int FLAG_BIT = 7;

  localparam int EV_RXC = 0;
  localparam int EV_TXC = 1;
  localparam int EV_BSY = 2;

  localparam logic [3:0] RA_CMD   = 4'd0;
  localparam logic [3:0] RA_EVT   = 4'd1;
  localparam logic [3:0] RA_MASK  = 4'd2;
  localparam logic [3:0] RA_RXD   = 4'd3;
  localparam logic [3:0] RA_TXD   = 4'd4;
  localparam logic [3:0] RA_IDX   = 4'd5;
  localparam logic [3:0] RA_RXBUF = 4'd6;
  localparam logic [3:0] RA_TXBUF = 4'd7;

  // A programmed length never exceeds the buffer depth.
  function automatic int clamp_len(int raw, int depth);
    return (raw > depth) ? depth : raw;
  endfunction

  // True when the slot about to be used is the last one before a limit.
  function automatic logic last_slot(int cnt, int limit);
    return (cnt + 1) == limit;
  endfunction

  function automatic logic irq_of(logic [EVT_N-1:0] ev, logic [EVT_N-1:0] en);
    return |(ev & en);
  endfunction

endpackage

// File: rtl/spi_sd_sync.sv
module spi_sd_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [STAGES:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/spi_sd_shift.sv
module spi_sd_shift
  import spi_sd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [CHAR_W-1:0] load_byte,
  output logic              load_take,
  output logic              byte_done,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              miso
);

  localparam int BIT_W = $clog2(CHAR_W);

  logic [BIT_W-1:0]  bit_cnt;
  logic [CHAR_W-1:0] rx_sh;
  logic [CHAR_W-1:0] tx_sh;

  wire at_boundary = (bit_cnt == '0);

  assign byte_done = sel_active && sclk_rise && (bit_cnt == BIT_W'(CHAR_W-1));
  assign rx_byte   = {rx_sh[CHAR_W-2:0], mosi_s};
  assign load_take = sel_fall || (sel_active && sclk_fall && at_boundary);
  assign miso      = sel_active ? tx_sh[CHAR_W-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
    end else if (sel_fall) begin
      bit_cnt <= '0;
      tx_sh   <= load_byte;
    end else if (sel_active) begin
      if (sclk_rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) begin
        if (at_boundary) tx_sh <= load_byte;
        else             tx_sh <= {tx_sh[CHAR_W-2:0], 1'b1};
      end
    end
  end

endmodule

// File: rtl/spi_sd_desc.sv
module spi_sd_desc
  import spi_sd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              rxd_wr,
  input  logic              rxd_empty_in,
  input  logic              txd_wr,
  input  logic              txd_ready_in,
  input  logic [CNT_W-1:0]  txd_len_in,
  input  logic              txbuf_wr,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [CHAR_W-1:0] txbuf_data,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              byte_done,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              load_take,
  output logic [CHAR_W-1:0] load_byte,
  output logic              armed,
  output logic              rx_empty,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              tx_ready,
  output logic [CNT_W-1:0]  tx_len,
  output logic [CHAR_W-1:0] rxbuf_q,
  output logic [CHAR_W-1:0] txbuf_q,
  output logic [EVT_N-1:0]  evt_set
);

  logic              session_q, armed_q, cur_buf_q;
  logic              rx_empty_q, tx_ready_q;
  logic [CNT_W-1:0]  rx_cnt_q, tx_len_q, tx_sent_q;
  logic [CHAR_W-1:0] rx_mem [DEPTH];
  logic [CHAR_W-1:0] tx_mem [DEPTH];

  // Named internal events
  wire part          = sel_fall ? armed_q : session_q;
  wire tx_avail      = tx_ready_q && (tx_sent_q < tx_len_q);
  wire rx_accept     = byte_done && session_q && rx_empty_q;
  wire rx_fill_close = rx_accept && last_slot(int'(rx_cnt_q), DEPTH);
  wire rx_sel_close  = sel_rise && session_q && rx_empty_q;
  wire busy_hit      = byte_done && session_q && !rx_empty_q;
  wire tx_done_byte  = byte_done && session_q && cur_buf_q;
  wire tx_close      = tx_done_byte && last_slot(int'(tx_sent_q), int'(tx_len_q));

  assign load_byte = (part && tx_avail) ? tx_mem[tx_sent_q[IDX_W-1:0]] : '1;

  assign evt_set[EV_RXC] = rx_fill_close || rx_sel_close;
  assign evt_set[EV_TXC] = tx_close;
  assign evt_set[EV_BSY] = busy_hit;

  assign armed    = armed_q;
  assign rx_empty = rx_empty_q;
  assign rx_cnt   = rx_cnt_q;
  assign tx_ready = tx_ready_q;
  assign tx_len   = tx_len_q;
  assign rxbuf_q  = rx_mem[buf_idx];
  assign txbuf_q  = tx_mem[buf_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session_q  <= 1'b0;
      armed_q    <= 1'b0;
      cur_buf_q  <= 1'b0;
      rx_empty_q <= 1'b0;
      tx_ready_q <= 1'b0;
      rx_cnt_q   <= '0;
      tx_len_q   <= '0;
      tx_sent_q  <= '0;
    end else begin
      if (sel_fall)      session_q <= armed_q;
      else if (sel_rise) session_q <= 1'b0;

      if (start_wr)                   armed_q <= 1'b1;
      else if (sel_rise && session_q) armed_q <= 1'b0;

      if (load_take)      cur_buf_q <= part && tx_avail;
      else if (byte_done) cur_buf_q <= 1'b0;

      if (rx_accept) rx_cnt_q <= rx_cnt_q + 1'b1;
      if (rx_fill_close || rx_sel_close) rx_empty_q <= 1'b0;

      if (tx_done_byte) tx_sent_q <= tx_sent_q + 1'b1;
      if (tx_close)     tx_ready_q <= 1'b0;

      if (rxd_wr) begin
        rx_empty_q <= rxd_empty_in;
        if (rxd_empty_in) rx_cnt_q <= '0;
      end
      if (txd_wr) begin
        tx_ready_q <= txd_ready_in;
        tx_len_q   <= CNT_W'(clamp_len(int'(txd_len_in), DEPTH));
        tx_sent_q  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rx_accept) rx_mem[rx_cnt_q[IDX_W-1:0]] <= rx_byte;
    if (txbuf_wr)  tx_mem[buf_idx] <= txbuf_data;
  end

  // Count never passes the buffer depth
  assert_rx_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt_q <= CNT_W'(DEPTH));

  // The byte that fills the buffer closes it at once
  assert_rx_full_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill_close && !rxd_wr) |=> (!rx_empty_q && rx_cnt_q == CNT_W'(DEPTH)));

  // A busy byte is dropped
  assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && !rxd_wr) |=> $stable(rx_cnt_q));

  // Bytes outside an armed session leave the receive count alone
  assert_unarmed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !session_q && !rxd_wr) |=> $stable(rx_cnt_q));

  // The last programmed byte drops the ready flag
  assert_tx_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_close && !txd_wr) |=> !tx_ready_q);

  assert_tx_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_q && tx_len_q != '0) |-> (tx_sent_q < tx_len_q));

  // Deselect keeps the transmit side as it was
  assert_desel_keeps_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && session_q && !txd_wr) |=> (tx_ready_q == $past(tx_ready_q)
                                             && tx_sent_q == $past(tx_sent_q)));

  // A finished session disarms the slave unless restarted
  assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && session_q && !start_wr) |=> !armed_q);

endmodule

// File: rtl/spi_sd_evt.sv
module spi_sd_evt
  import spi_sd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_set,
  input  logic             clr_wr,
  input  logic [EVT_N-1:0] clr_bits,
  input  logic             mask_wr,
  input  logic [EVT_N-1:0] mask_in,
  output logic [EVT_N-1:0] evt,
  output logic [EVT_N-1:0] mask,
  output logic             irq
);

  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q <= 1'b0;
      else if (evt_set[i])           q <= 1'b1;
      else if (clr_wr && clr_bits[i]) q <= 1'b0;
    end
    assign evt[i] = q;

    // Writing one clears a bit that is not being set
    assert_evt_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[i] && !evt_set[i]) |=> !evt[i]);

    // A hardware set is never lost to a clear
    assert_evt_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[i] |=> evt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= mask_in;
  end

  assign irq = irq_of(evt, mask);

endmodule

// File: rtl/spi_sd_slave.sv
module spi_sd_slave
  import spi_sd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       spi_sclk,
  input  logic       spi_ss_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int L_SS = 2;
  localparam int L_CK = 1;
  localparam int L_DI = 0;

  logic [2:0] ln_q, ln_rise, ln_fall;

  spi_sd_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_ss_n, spi_sclk, spi_mosi}),
    .q(ln_q), .rise(ln_rise), .fall(ln_fall)
  );

  wire sel_fall   = ln_fall[L_SS];
  wire sel_rise   = ln_rise[L_SS];
  wire sel_active = !ln_q[L_SS];
  wire sclk_rise  = ln_rise[L_CK];
  wire sclk_fall  = ln_fall[L_CK];
  wire mosi_s     = ln_q[L_DI];
  wire unused_lines = ^{ln_q[L_CK], ln_rise[L_DI], ln_fall[L_DI]};

  // Register decode
  wire wr_cmd   = reg_we && reg_addr == RA_CMD && reg_wdata[0];
  wire wr_evt   = reg_we && reg_addr == RA_EVT;
  wire wr_mask  = reg_we && reg_addr == RA_MASK;
  wire wr_rxd   = reg_we && reg_addr == RA_RXD;
  wire wr_txd   = reg_we && reg_addr == RA_TXD;
  wire wr_idx   = reg_we && reg_addr == RA_IDX;
  wire wr_txbuf = reg_we && reg_addr == RA_TXBUF;

  logic [IDX_W-1:0] idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (wr_idx) idx_q <= reg_wdata[IDX_W-1:0];
  end

  logic              load_take, byte_done;
  logic [CHAR_W-1:0] rx_byte, load_byte, rxbuf_q, txbuf_q;
  logic              armed, rx_empty, tx_ready;
  logic [CNT_W-1:0]  rx_cnt, tx_len;
  logic [EVT_N-1:0]  evt_set, evt, mask;

  spi_sd_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_fall(sel_fall), .sel_active(sel_active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .load_byte(load_byte), .load_take(load_take),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_sd_desc #(.DEPTH(DEPTH)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .start_wr(wr_cmd),
    .rxd_wr(wr_rxd), .rxd_empty_in(reg_wdata[FLAG_BIT]),
    .txd_wr(wr_txd), .txd_ready_in(reg_wdata[FLAG_BIT]),
    .txd_len_in(reg_wdata[CNT_W-1:0]),
    .txbuf_wr(wr_txbuf), .buf_idx(idx_q), .txbuf_data(reg_wdata[CHAR_W-1:0]),
    .sel_fall(sel_fall), .sel_rise(sel_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .load_take(load_take),
    .load_byte(load_byte), .armed(armed),
    .rx_empty(rx_empty), .rx_cnt(rx_cnt),
    .tx_ready(tx_ready), .tx_len(tx_len),
    .rxbuf_q(rxbuf_q), .txbuf_q(txbuf_q),
    .evt_set(evt_set)
  );

  spi_sd_evt u_evt (
    .clk(clk), .rst_n(rst_n),
    .evt_set(evt_set),
    .clr_wr(wr_evt), .clr_bits(reg_wdata[EVT_N-1:0]),
    .mask_wr(wr_mask), .mask_in(reg_wdata[EVT_N-1:0]),
    .evt(evt), .mask(mask), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CMD:   reg_rdata[0] = armed;
      RA_EVT:   reg_rdata[EVT_N-1:0] = evt;
      RA_MASK:  reg_rdata[EVT_N-1:0] = mask;
      RA_RXD: begin
        reg_rdata[FLAG_BIT]  = rx_empty;
        reg_rdata[CNT_W-1:0] = rx_cnt;
      end
      RA_TXD: begin
        reg_rdata[FLAG_BIT]  = tx_ready;
        reg_rdata[CNT_W-1:0] = tx_len;
      end
      RA_IDX:   reg_rdata[IDX_W-1:0] = idx_q;
      RA_RXBUF: reg_rdata[CHAR_W-1:0] = rxbuf_q;
      RA_TXBUF: reg_rdata[CHAR_W-1:0] = txbuf_q;
      default:  reg_rdata = {REG_W{unused_lines & 1'b0}};
    endcase
  end

  // Idle line stays high once select has been released
  assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ln_q[L_SS]) && ln_q[L_SS]) |-> spi_miso);

endmodule

// File: tb/spi_sd_slave_tb.sv
module spi_sd_slave_tb;

  localparam int CLK_P = 10;
  localparam int HB    = 8;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, irq;

  always #(CLK_P/2) clk = ~clk;

  spi_sd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk),
    .spi_ss_n(ss_n), .spi_mosi(mosi), .spi_miso(miso), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0, settled = 0;

  // Behavioural reference model
  int m_evt = 0, m_mask = 0, m_armed = 0, m_session = 0, m_idx = 0;
  int m_rx_empty = 0, m_rx_cnt = 0, m_tx_ready = 0, m_tx_len = 0, m_tx_sent = 0;
  logic [7:0] m_rx [DEPTH];
  logic [7:0] m_tx [DEPTH];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (settled && rst_n && !done) begin
      chk("R10 irq", int'(irq), int'((m_evt & m_mask) != 0));
      if (ss_n) chk("R1 idle miso", int'(miso), 1);
    end
  end

  task automatic model_wr(input int a, input logic [7:0] d);
    case (a)
      0: if (d[0]) m_armed = 1;
      1: m_evt = m_evt & ~int'(d[2:0]);
      2: m_mask = int'(d[2:0]);
      3: begin m_rx_empty = int'(d[7]); if (d[7]) m_rx_cnt = 0; end
      4: begin
           m_tx_ready = int'(d[7]);
           m_tx_len = (int'(d[4:0]) > DEPTH) ? DEPTH : int'(d[4:0]);
           m_tx_sent = 0;
         end
      5: m_idx = int'(d[3:0]);
      7: m_tx[m_idx] = d;
      default: ;
    endcase
  endtask

  task automatic sw_write(input int a, input logic [7:0] d);
    settled = 0;
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
    settled = 1;
  endtask

  task automatic reg_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] d;
    reg_rd(1, d); chk({tag, " events"}, int'(d), m_evt);
    reg_rd(2, d); chk({tag, " mask"}, int'(d), m_mask);
    reg_rd(3, d); chk({tag, " rx descriptor"}, int'(d), (m_rx_empty << 7) | m_rx_cnt);
    reg_rd(4, d); chk({tag, " tx descriptor"}, int'(d), (m_tx_ready << 7) | m_tx_len);
    reg_rd(0, d); chk({tag, " armed"}, int'(d), m_armed);
  endtask

  task automatic check_rx_buf(input string tag, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      sw_write(5, 8'(i));
      reg_rd(6, d);
      chk({tag, " rx slot"}, int'(d), int'(m_rx[i]));
    end
  endtask

  task automatic sel_on();
    settled = 0;
    @(negedge clk) ss_n = 1'b0;
    m_session = m_armed;
    repeat (HB) @(negedge clk);
    settled = 1;
  endtask

  task automatic sel_off();
    settled = 0;
    @(negedge clk) ss_n = 1'b1;
    repeat (HB) @(negedge clk);
    if (m_session != 0 && m_rx_empty != 0) begin
      m_rx_empty = 0;
      m_evt = m_evt | 1;
    end
    if (m_session != 0) m_armed = 0;
    m_session = 0;
    settled = 1;
  endtask

  task automatic byte_xfer(input logic [7:0] b, input string tag);
    logic [7:0] exp, got;
    bit from_buf;
    settled = 0;
    from_buf = (m_session != 0) && (m_tx_ready != 0) && (m_tx_sent < m_tx_len);
    exp = from_buf ? m_tx[m_tx_sent] : 8'hFF;
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk) mosi = b[k];
      repeat (HB-1) @(negedge clk);
      sclk = 1'b1;
      got[k] = miso;
      repeat (HB) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HB) @(negedge clk);
    chk({tag, " miso byte"}, int'(got), int'(exp));
    if (m_session != 0) begin
      if (from_buf) begin
        m_tx_sent++;
        if (m_tx_sent == m_tx_len) begin m_tx_ready = 0; m_evt = m_evt | 2; end
      end
      if (m_rx_empty != 0) begin
        m_rx[m_rx_cnt] = b;
        m_rx_cnt++;
        if (m_rx_cnt == DEPTH) begin m_rx_empty = 0; m_evt = m_evt | 1; end
      end else begin
        m_evt = m_evt | 4;
      end
    end
    settled = 1;
  endtask

  initial begin
    logic [7:0] tx_pat [5];
    tx_pat = '{8'hA5, 8'h3C, 8'h81, 8'h7E, 8'h01};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state, R12 map
    check_regs("R1 R12");
    chk("R1 irq", int'(irq), 0);
    chk("R1 miso", int'(miso), 1);
    settled = 1;

    // R2: descriptors prepared but no start
    for (int i = 0; i < 5; i++) begin sw_write(5, 8'(i)); sw_write(7, tx_pat[i]); end
    sw_write(3, 8'h80);
    sw_write(4, 8'h85);
    sel_on(); byte_xfer(8'h5A, "R2"); byte_xfer(8'hC3, "R2"); sel_off();
    check_regs("R2");

    // R3 R4 R6: armed, short session
    sw_write(2, 8'h07);
    sw_write(0, 8'h01);
    check_regs("R11 armed");
    sel_on();
    byte_xfer(8'h11, "R4"); byte_xfer(8'h96, "R4"); byte_xfer(8'h0F, "R4");
    sel_off();
    check_regs("R6");
    check_rx_buf("R3", 3);

    // R9 partial clears
    sw_write(1, 8'h02); check_regs("R9 no-op clear");
    sw_write(1, 8'h01); check_regs("R9 clear");

    // R5 R11: resume transmit, close after length
    sw_write(3, 8'h80);
    sw_write(0, 8'h01);
    sel_on();
    for (int i = 0; i < 4; i++) byte_xfer(8'(8'h40 + i), "R5");
    sel_off();
    check_regs("R5");
    sw_write(2, 8'h04); check_regs("R10 masked");
    sw_write(2, 8'h02); check_regs("R10 tx mask");
    sw_write(1, 8'hFF); check_regs("R9 clear all");

    // R7: exactly full then deselect
    sw_write(2, 8'h07);
    sw_write(3, 8'h80);
    sw_write(0, 8'h01);
    sel_on();
    for (int i = 0; i < DEPTH; i++) byte_xfer(8'(i * 7 + 3), "R7");
    check_regs("R7 closed full");
    sel_off();
    check_regs("R7 no busy");
    check_rx_buf("R7", DEPTH);
    sw_write(1, 8'hFF);

    // R8: overflow
    sw_write(3, 8'h80);
    sw_write(0, 8'h01);
    sel_on();
    for (int i = 0; i < DEPTH + 2; i++) byte_xfer(8'(8'hE0 ^ i), "R8");
    sel_off();
    check_regs("R8 busy");
    check_rx_buf("R8", DEPTH);
    sw_write(1, 8'hFF);

    // R11: disarmed after session; re-arm; transmit rewrite restarts at slot 0
    sel_on(); byte_xfer(8'h77, "R11 disarmed"); sel_off();
    check_regs("R11 disarmed");
    sw_write(4, 8'h82);
    sw_write(3, 8'h80);
    sw_write(0, 8'h01);
    sel_on();
    for (int i = 0; i < 3; i++) byte_xfer(8'(8'h21 + i), "R11 R4 restart");
    sel_off();
    check_regs("R11 R5");
    check_rx_buf("R11", 3);

    // R5 length clamp
    sw_write(4, 8'h9F);
    check_regs("R5 clamp");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule